// File: doc/BRIEF.md
# Output-Stationary Systolic FIR Array

This block is a finite impulse response filter built as a ring of processing elements (PEs). Every accepted input sample is broadcast to all PEs in the same clock cycle. The filter coefficients circulate around the ring, moving one PE per accepted sample. Each PE keeps one output sample in its own accumulator, so partial sums never move. Each cycle every PE performs one multiply-accumulate.

After a PE has gathered all `TAPS` products, it hands its finished sum to the output register and starts its next output from zero. Finished outputs therefore leave the PEs in rotation, and they still reach the port in sample order.

Coefficients arrive serially on a load strobe. A load also restarts the filter, so later outputs treat all earlier input as zero. While no sample is offered, the array stalls.

Top module: `osfir_array`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 0, and every accumulator and every coefficient slot is zero.
- R2: Each cycle with `coef_load` high shifts `coef_data` into the coefficient ring. After `TAPS` load cycles, the first value loaded is tap 0, which multiplies the newest sample, and the last value loaded is tap `TAPS-1`.
- R3: A load cycle clears every partial sum and restarts the output rotation. Samples accepted before the load have no effect on any output produced after it.
- R4: A sample is accepted when `smp_valid` is high and `coef_load` is low. Each accepted sample gives exactly one cycle of `out_valid` on the following clock cycle, and `out_valid` is low in every other cycle.
- R5: The output for accepted sample n equals the sum over j = 0..TAPS-1 of w(j)·x(n−j), using signed two's-complement values. Samples before the first one accepted after a load count as zero.
- R6: While no sample is accepted, coefficients, accumulators and `out_data` hold their values. Idle gaps between samples do not change any output value.
- R7: A sample offered in the same cycle as `coef_load` is discarded and produces no output.
- R8: The accumulators and `out_data` are `XW+CW+clog2(TAPS)` bits wide, so the most negative inputs and coefficients on every tap give the exact result, with no overflow.
- R9: Outputs come out in sample order across any number of trips around the ring. The finishing PE advances by one per accepted sample and wraps from `TAPS-1` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid | input | 1 | Input sample present this cycle |
| smp_data | input | XW | Signed input sample, broadcast to every PE |
| coef_load | input | 1 | Shift `coef_data` into the coefficient ring and restart the filter |
| coef_data | input | CW | Signed coefficient value |
| out_valid | output | 1 | `out_data` holds a newly completed output |
| out_data | output | XW+CW+clog2(TAPS) | Signed filter output |

## Verification
The hardest case to reach from the ports is a finished output whose sum was gathered across a full ring wrap. It must also include idle gaps and follow a restart, so that both stale sums and stale coefficient positions could corrupt it. The stimulus streams more samples than there are PEs, with irregular idle cycles between them. It then reloads the coefficients while a sample is offered in the final load cycle, and streams again at once. Each output is compared against a convolution computed in the bench from the recorded sample history.

// File: rtl/osfir_pkg.sv
package osfir_pkg;
  // Width that holds TAPS signed products without overflow.
  function automatic int unsigned acc_width(int unsigned xw, int unsigned cw,
                                            int unsigned taps);
    return xw + cw + ((taps > 1) ? $clog2(taps) : 1);
  endfunction

  function automatic int unsigned ptr_width(int unsigned taps);
    return (taps > 1) ? $clog2(taps) : 1;
  endfunction
endpackage

// File: rtl/osfir_pe.sv
module osfir_pe #(
  parameter int unsigned XW = 8,
  parameter int unsigned CW = 8,
  parameter int unsigned AW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 fin,
  input  logic                 clr,
  input  logic signed [XW-1:0] x,
  input  logic signed [CW-1:0] w,
  output logic signed [AW-1:0] total
);
  localparam int unsigned PW = XW + CW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc_q, acc_d;

  assign prod  = x * w;
  assign total = acc_q + {{(AW-PW){prod[PW-1]}}, prod};

  always_comb begin
    acc_d = acc_q;
    if (clr)      acc_d = '0;
    else if (en)  acc_d = fin ? '0 : total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  p_pe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(acc_q));
  p_pe_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
  p_pe_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fin) |=> (acc_q == '0));
endmodule

// File: rtl/osfir_coef_ring.sv
module osfir_coef_ring #(
  parameter int unsigned TAPS = 4,
  parameter int unsigned CW   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      shift,
  input  logic [CW-1:0]             coef_in,
  output logic [TAPS-1:0][CW-1:0]   w_q
);
  logic [TAPS-1:0][CW-1:0] w_d;

  always_comb begin
    w_d = w_q;
    if (load) begin
      for (int k = 0; k < TAPS - 1; k++) w_d[k] = w_q[k+1];
      w_d[TAPS-1] = coef_in;
    end else if (shift) begin
      w_d[0] = w_q[TAPS-1];
      for (int k = 1; k < TAPS; k++) w_d[k] = w_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) w_q <= '0;
    else        w_q <= w_d;
  end

  p_ring_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(w_q));
  p_ring_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (w_q[0] == $past(w_q[TAPS-1])));
  p_ring_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (w_q[TAPS-1] == $past(coef_in)));
endmodule

// File: rtl/osfir_ctrl.sv
module osfir_ctrl #(
  parameter int unsigned TAPS = 4,
  parameter int unsigned PW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            smp_valid,
  output logic            accept,
  output logic [PW-1:0]   ptr_q,
  output logic [TAPS-1:0] fin_vec
);
  localparam logic [PW-1:0] LAST = PW'(TAPS - 1);

  logic [PW-1:0] ptr_d;

  assign accept = smp_valid && !load;

  for (genvar k = 0; k < TAPS; k++) begin : g_fin
    assign fin_vec[k] = accept && (ptr_q == PW'(k));
  end

  always_comb begin
    ptr_d = ptr_q;
    if (load)        ptr_d = '0;
    else if (accept) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  p_ptr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ptr_q == LAST) |=> (ptr_q == '0));
  p_ptr_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr_q == '0));
  p_ptr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);
endmodule

// File: rtl/osfir_array.sv
module osfir_array #(
  parameter int unsigned TAPS = 4,
  parameter int unsigned XW   = 8,
  parameter int unsigned CW   = 8,
  localparam int unsigned AW  = osfir_pkg::acc_width(XW, CW, TAPS),
  localparam int unsigned PW  = osfir_pkg::ptr_width(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [XW-1:0] smp_data,
  input  logic                 coef_load,
  input  logic signed [CW-1:0] coef_data,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic                    accept;
  logic [PW-1:0]           ptr_q;
  logic [TAPS-1:0]         fin_vec;
  logic [TAPS-1:0][CW-1:0] w_q;
  logic [TAPS-1:0][AW-1:0] pe_total;

  osfir_ctrl #(.TAPS(TAPS), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_q), .load(coef_load), .smp_valid(smp_valid),
    .accept(accept), .ptr_q(ptr_q), .fin_vec(fin_vec)
  );

  osfir_coef_ring #(.TAPS(TAPS), .CW(CW)) u_ring (
    .clk(clk), .rst_n(rst_sync_q), .load(coef_load), .shift(accept),
    .coef_in(coef_data), .w_q(w_q)
  );

  for (genvar k = 0; k < TAPS; k++) begin : g_pe
    osfir_pe #(.XW(XW), .CW(CW), .AW(AW)) u_pe (
      .clk(clk), .rst_n(rst_sync_q), .en(accept), .fin(fin_vec[k]),
      .clr(coef_load), .x(smp_data), .w($signed(w_q[k])),
      .total(pe_total[k])
    );
  end

  logic          out_valid_q, out_valid_d;
  logic [AW-1:0] out_data_q, out_data_d;

  always_comb begin
    out_valid_d = accept;
    out_data_d  = out_data_q;
    if (accept) out_data_d = pe_total[ptr_q];
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= out_valid_d;
      out_data_q  <= out_data_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  p_out_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (smp_valid && !coef_load) |=> out_valid);
  p_drop_on_load_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(smp_valid && !coef_load) |=> !out_valid);
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !out_valid |-> $stable(out_data));
  p_one_finisher_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(fin_vec));
endmodule

// File: tb/osfir_array_bench.sv
module osfir_array_bench;
  localparam int TAPS = 4;
  localparam int XW   = 8;
  localparam int CW   = 8;
  localparam int AW   = XW + CW + $clog2(TAPS);

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 smp_valid;
  logic signed [XW-1:0] smp_data;
  logic                 coef_load;
  logic signed [CW-1:0] coef_data;
  logic                 out_valid;
  logic signed [AW-1:0] out_data;

  always #2.5ns clk = ~clk;

  osfir_array #(.TAPS(TAPS), .XW(XW), .CW(CW)) u_osfir_array (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .coef_load(coef_load), .coef_data(coef_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int     checks = 0;
  int     errors = 0;
  int     sent   = 0;
  int     seen   = 0;
  string  cur_tag = "R5";
  longint exp_q[$];
  string  tag_q[$];
  longint hist[$];
  int     coefs[TAPS];

  task automatic report_summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      smp_valid = 1'b0;
      coef_load = 1'b0;
    end
  endtask

  // driver: applies one sample and queues its expected output
  task automatic drive_sample(input int v);
    longint e;
    @(negedge clk);
    smp_valid = 1'b1;
    coef_load = 1'b0;
    smp_data  = XW'(v);
    hist.push_front(longint'(v));
    if (hist.size() > TAPS) void'(hist.pop_back());
    e = 0;
    for (int j = 0; j < hist.size(); j++) e += longint'(coefs[j]) * hist[j];
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
    sent++;
  endtask

  // loads a coefficient set; optionally offers a sample on the last load cycle
  task automatic load_set(input int c[TAPS], input bit with_sample);
    for (int k = 0; k < TAPS; k++) begin
      @(negedge clk);
      coef_load = 1'b1;
      coef_data = CW'(c[k]);
      smp_valid = with_sample && (k == TAPS - 1);
      smp_data  = 8'sh55;
      for (int m = 0; m < TAPS - 1; m++) coefs[m] = coefs[m+1];
      coefs[TAPS-1] = c[k];
    end
    hist.delete();
    @(negedge clk);
    coef_load = 1'b0;
    smp_valid = 1'b0;
    if (with_sample)
      chk(out_valid == 1'b0, "R7", longint'(out_valid), 0);
  endtask

  // monitor: pops expected values as outputs appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected output", longint'(out_data), 0);
      end else begin
        longint e;
        string  t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(longint'(out_data) == e, t, longint'(out_data), e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report_summary();
    $finish;
  end

  initial begin
    int set_a[TAPS];
    int set_b[TAPS];
    int stream[10];
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    coef_load = 1'b0;
    coef_data = '0;
    for (int k = 0; k < TAPS; k++) coefs[k] = 0;
    set_a  = '{3, -2, 5, 7};
    set_b  = '{-128, -128, -128, -128};
    stream = '{12, -7, 100, -128, 127, 0, 33, -1, 64, -90};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1: outputs quiet and zero after reset
    chk(out_valid == 1'b0, "R1 out_valid", longint'(out_valid), 0);
    chk(out_data == '0, "R1 out_data", longint'(out_data), 0);
    // R1: zero coefficients give zero output
    cur_tag = "R1";
    drive_sample(77);
    idle(2);

    // R2: impulse response reproduces the taps in load order
    load_set(set_a, 1'b0);
    cur_tag = "R2";
    drive_sample(1);
    for (int k = 0; k < TAPS; k++) drive_sample(0);
    idle(2);

    // R6 and R9: long stream with irregular gaps across several ring wraps
    cur_tag = "R6";
    for (int k = 0; k < 10; k++) begin
      drive_sample(stream[k]);
      if (k % 3 == 1) idle(k % 4 + 1);
    end
    cur_tag = "R9";
    for (int k = 0; k < 10; k++) drive_sample(stream[9-k]);
    idle(3);
    chk(out_valid == 1'b0, "R4 idle", longint'(out_valid), 0);

    // R7 and R3: reload with a sample offered during the load, then restart
    load_set(set_a, 1'b1);
    cur_tag = "R3";
    for (int k = 0; k < TAPS; k++) drive_sample(stream[k] + 5);
    cur_tag = "R5";
    for (int k = 0; k < 6; k++) drive_sample(stream[k+3]);
    idle(2);

    // R8: extreme negative values on every tap
    load_set(set_b, 1'b0);
    cur_tag = "R8";
    for (int k = 0; k < 6; k++) drive_sample(-128);
    drive_sample(127);
    idle(3);

    chk(exp_q.size() == 0, "R4 pending", longint'(exp_q.size()), 0);
    chk(seen == sent, "R4 count", longint'(seen), longint'(sent));
    report_summary();
    $finish;
  end
endmodule